// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block is a hardware state machine that brings a high-speed serial PHY out of its powered-down state by stepping its analog control pins through a fixed order. Each step changes one or a few pins and then holds for a fixed number of microseconds. The wait is counted on a one-microsecond tick strobe that the block receives from outside. Software or a boot controller only has to pulse `start_i`. It then waits for `done_o` and reads `err_o`.

After both reset-bars are released, the block polls the PLL lock input once per tick. If lock does not appear within the retry budget, the block pulses the PLL reset-bar low for one clock and runs the poll a second time. If lock is still absent after that, it raises a sticky error. Whether lock passed or failed, the mode-code output is then switched to a parked value that does not drive the lines low.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, every pin output, `mode_o`, `done_o` and `err_o` are 0. Isolation is off, and every power-down-bar and reset-bar is low.
- R2: A start pulse accepted in idle asserts `iso_o` on the next clock. IDDQ is asserted on the `ISO_US`-th tick (default 10) and no earlier.
- R3: `IDDQ_US` ticks (default 10) after IDDQ rises, one clock clears bandgap, PLL and LDO power-down-bar and core-ready, and loads `mode_i` into `mode_o`. Core-ready rises again on the `CFG_US`-th tick after that (default 160).
- R4: Bandgap power-down-bar rises `CORE_US` ticks (default 50) after core-ready. `BG_US` ticks (default 200) later, the next step starts.
- R5: `pwr_on_o` and `ldo_pdb_o` rise on the same clock. `pwr_ok_o` follows `LDO_US` ticks (default 10) later.
- R6: After `PGOOD_US` ticks (default 10), PLL power-down-bar rises. After `PLL_US` ticks (default 10), isolation clears. After `UNISO_US` ticks (default 10), IDDQ clears. After `UNIDDQ_US` ticks (default 1), `pll_rstb_o` and `phy_rstb_o` rise on the same clock.
- R7: Lock is sampled on each tick, for up to `LOCK_TRIES` ticks (default 8). The first tick that sees `lock_i` high ends the sequence on that clock, with `done_o` high and `err_o` low.
- R8: If every sample in the first poll misses lock, `pll_rstb_o` is low for exactly one clock and the poll runs once more. If the second poll also misses, `done_o` and `err_o` are raised together.
- R9: On the clock `done_o` is high, `mode_o` equals `MODE_PARK` (default 4), both after a pass and after a failure.
- R10: A start pulse that arrives while the sequence is running has no effect: it does not restart the step timer.
- R11: `done_o` is high for exactly one clock per sequence. `err_o` stays set until the next accepted start, which clears it.
- R12: An accepted start drives both reset-bars low and clears `pwr_on_o` and `pwr_ok_o` on the same clock that asserts isolation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| tick_i | input | 1 | One-clock strobe per microsecond |
| mode_i | input | MODE_W | Mode code applied in the configuration step |
| lock_i | input | 1 | PLL lock status |
| iso_o | output | 1 | PHY isolation |
| iddq_o | output | 1 | IDDQ (quiescent) control |
| bg_pdb_o | output | 1 | Bandgap power-down-bar |
| pll_pdb_o | output | 1 | PLL power-down-bar |
| ldo_pdb_o | output | 1 | LDO power-down-bar |
| core_rdy_o | output | 1 | Core-ready |
| pwr_on_o | output | 1 | Power switch on input |
| pwr_ok_o | output | 1 | Power switch good input |
| mode_o | output | MODE_W | Mode code to the PHY |
| pll_rstb_o | output | 1 | PLL reset-bar |
| phy_rstb_o | output | 1 | PHY reset-bar |
| done_o | output | 1 | One-clock end-of-sequence pulse |
| err_o | output | 1 | Lock failure, sticky until next start |

## Verification
The bench counts ticks up to the boundary of each wait and checks that the step has not yet happened one tick early and has happened on the exact tick. A timer reloaded off by one would fail both checks.

The lock phase is exercised three ways: lock on the first sample, lock only after the reset-bar pulse, and lock never. A design that skipped the second poll, held the reset-bar low too long or forgot to park the mode code on the failing path would show it at `pll_rstb_o`, `err_o` or `mode_o`.

A start pulse injected halfway through the first wait would push IDDQ late if it reloaded the timer. A restart after a failure must clear the error, and it must pull both reset-bars low before anything else moves.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISO, ST_IDDQ, ST_CFG, ST_CORE, ST_BG, ST_LDO, ST_PGOOD,
    ST_PLL, ST_UNISO, ST_UNIDDQ, ST_POLL, ST_TOGGLE, ST_FINISH
  } seq_state_e;

  typedef struct packed {
    logic iso;
    logic iddq;
    logic bg_pdb;
    logic pll_pdb;
    logic ldo_pdb;
    logic core_rdy;
    logic pwr_on;
    logic pwr_ok;
    logic pll_rstb;
    logic phy_rstb;
  } pin_set_t;

  localparam pin_set_t PINS_SAFE = '0;

  function automatic logic is_wait_step(seq_state_e s);
    return (s >= ST_ISO) && (s <= ST_UNIDDQ);
  endfunction

endpackage

// File: rtl/phy_pwr_wait.sv
module phy_pwr_wait #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/phy_pwr_lock_poll.sv
module phy_pwr_lock_poll #(
  parameter int unsigned TRIES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  output logic exhausted_o
);

  localparam int unsigned CW = $clog2(TRIES + 1);

  logic [CW-1:0] cnt_q;

  assign exhausted_o = sample_i && (cnt_q == CW'(TRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (sample_i)  cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int unsigned MODE_W     = 3,
  parameter logic [MODE_W-1:0] MODE_PARK = 3'd4,
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned LOCK_TRIES = 8,
  parameter int unsigned ISO_US     = 10,
  parameter int unsigned IDDQ_US    = 10,
  parameter int unsigned CFG_US     = 160,
  parameter int unsigned CORE_US    = 50,
  parameter int unsigned BG_US      = 200,
  parameter int unsigned LDO_US     = 10,
  parameter int unsigned PGOOD_US   = 10,
  parameter int unsigned PLL_US     = 10,
  parameter int unsigned UNISO_US   = 10,
  parameter int unsigned UNIDDQ_US  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lock_i,
  output logic              iso_o,
  output logic              iddq_o,
  output logic              bg_pdb_o,
  output logic              pll_pdb_o,
  output logic              ldo_pdb_o,
  output logic              core_rdy_o,
  output logic              pwr_on_o,
  output logic              pwr_ok_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              pll_rstb_o,
  output logic              phy_rstb_o,
  output logic              done_o,
  output logic              err_o
);

  seq_state_e        state_q, state_d;
  pin_set_t          pins_q;
  logic [MODE_W-1:0] mode_q;
  logic              err_q, retried_q, fail;
  logic              entering, expire, exhausted;
  logic [WAIT_W-1:0] wait_val;

  function automatic logic [WAIT_W-1:0] wait_of(seq_state_e s);
    case (s)
      ST_ISO:    return WAIT_W'(ISO_US);
      ST_IDDQ:   return WAIT_W'(IDDQ_US);
      ST_CFG:    return WAIT_W'(CFG_US);
      ST_CORE:   return WAIT_W'(CORE_US);
      ST_BG:     return WAIT_W'(BG_US);
      ST_LDO:    return WAIT_W'(LDO_US);
      ST_PGOOD:  return WAIT_W'(PGOOD_US);
      ST_PLL:    return WAIT_W'(PLL_US);
      ST_UNISO:  return WAIT_W'(UNISO_US);
      ST_UNIDDQ: return WAIT_W'(UNIDDQ_US);
      default:   return '0;
    endcase
  endfunction

  function automatic seq_state_e step_after(seq_state_e s);
    case (s)
      ST_ISO:    return ST_IDDQ;
      ST_IDDQ:   return ST_CFG;
      ST_CFG:    return ST_CORE;
      ST_CORE:   return ST_BG;
      ST_BG:     return ST_LDO;
      ST_LDO:    return ST_PGOOD;
      ST_PGOOD:  return ST_PLL;
      ST_PLL:    return ST_UNISO;
      ST_UNISO:  return ST_UNIDDQ;
      default:   return ST_POLL;
    endcase
  endfunction

  assign entering = (state_d != state_q);
  assign wait_val = wait_of(state_d);

  phy_pwr_wait #(.CNT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (entering && is_wait_step(state_d)),
    .load_val_i (wait_val),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  phy_pwr_lock_poll #(.TRIES(LOCK_TRIES)) u_poll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (entering && state_d == ST_POLL),
    .sample_i    (state_q == ST_POLL && tick_i),
    .exhausted_o (exhausted)
  );

  always_comb begin
    state_d = state_q;
    fail    = 1'b0;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ISO;
      ST_POLL: begin
        if (tick_i && lock_i) state_d = ST_FINISH;
        else if (exhausted) begin
          if (retried_q) begin
            state_d = ST_FINISH;
            fail    = 1'b1;
          end else begin
            state_d = ST_TOGGLE;
          end
        end
      end
      ST_TOGGLE: state_d = ST_POLL;
      ST_FINISH: state_d = ST_IDLE;
      default:   if (expire) state_d = step_after(state_q);
    endcase
  end

  // Pin changes are entry actions of the state being entered.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pins_q    <= PINS_SAFE;
      mode_q    <= '0;
      err_q     <= 1'b0;
      retried_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (entering) begin
        case (state_d)
          ST_ISO: begin
            pins_q.iso      <= 1'b1;
            pins_q.pll_rstb <= 1'b0;
            pins_q.phy_rstb <= 1'b0;
            pins_q.pwr_on   <= 1'b0;
            pins_q.pwr_ok   <= 1'b0;
            err_q           <= 1'b0;
            retried_q       <= 1'b0;
          end
          ST_IDDQ: pins_q.iddq <= 1'b1;
          ST_CFG: begin
            pins_q.bg_pdb   <= 1'b0;
            pins_q.pll_pdb  <= 1'b0;
            pins_q.ldo_pdb  <= 1'b0;
            pins_q.core_rdy <= 1'b0;
            mode_q          <= mode_i;
          end
          ST_CORE:  pins_q.core_rdy <= 1'b1;
          ST_BG:    pins_q.bg_pdb   <= 1'b1;
          ST_LDO: begin
            pins_q.pwr_on  <= 1'b1;
            pins_q.ldo_pdb <= 1'b1;
          end
          ST_PGOOD:  pins_q.pwr_ok  <= 1'b1;
          ST_PLL:    pins_q.pll_pdb <= 1'b1;
          ST_UNISO:  pins_q.iso     <= 1'b0;
          ST_UNIDDQ: pins_q.iddq    <= 1'b0;
          ST_POLL: begin
            pins_q.pll_rstb <= 1'b1;
            pins_q.phy_rstb <= 1'b1;
          end
          ST_TOGGLE: begin
            pins_q.pll_rstb <= 1'b0;
            retried_q       <= 1'b1;
          end
          ST_FINISH: begin
            mode_q <= MODE_PARK;
            if (fail) err_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign iso_o      = pins_q.iso;
  assign iddq_o     = pins_q.iddq;
  assign bg_pdb_o   = pins_q.bg_pdb;
  assign pll_pdb_o  = pins_q.pll_pdb;
  assign ldo_pdb_o  = pins_q.ldo_pdb;
  assign core_rdy_o = pins_q.core_rdy;
  assign pwr_on_o   = pins_q.pwr_on;
  assign pwr_ok_o   = pins_q.pwr_ok;
  assign pll_rstb_o = pins_q.pll_rstb;
  assign phy_rstb_o = pins_q.phy_rstb;
  assign mode_o     = mode_q;
  assign done_o     = (state_q == ST_FINISH);
  assign err_o      = err_q;

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int unsigned MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_PARK = 3'd4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              iso_o,
  input logic              iddq_o,
  input logic              bg_pdb_o,
  input logic              pll_pdb_o,
  input logic              ldo_pdb_o,
  input logic              pwr_on_o,
  input logic              pwr_ok_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              pll_rstb_o,
  input logic              phy_rstb_o,
  input logic              done_o,
  input logic              err_o
);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  park_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mode_o == MODE_PARK);

  // R8
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  // R11
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(start_i));

  // R6
  rstb_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rstb_o |-> (!iso_o && !iddq_o));

  // R4
  pll_after_bg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_pdb_o |-> (bg_pdb_o && ldo_pdb_o));

  // R5
  ok_after_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ok_o |-> pwr_on_o);

  // R12
  iso_drops_rstb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> (!pll_rstb_o && !phy_rstb_o && !pwr_on_o));

endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.MODE_W(MODE_W), .MODE_PARK(MODE_PARK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .iso_o      (iso_o),
  .iddq_o     (iddq_o),
  .bg_pdb_o   (bg_pdb_o),
  .pll_pdb_o  (pll_pdb_o),
  .ldo_pdb_o  (ldo_pdb_o),
  .pwr_on_o   (pwr_on_o),
  .pwr_ok_o   (pwr_ok_o),
  .mode_o     (mode_o),
  .pll_rstb_o (pll_rstb_o),
  .phy_rstb_o (phy_rstb_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

  localparam int unsigned MODE_W = 3;
  localparam int PARK = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0, lock_i = 1'b0;
  logic [MODE_W-1:0] mode_i = '0;
  logic iso_o, iddq_o, bg_pdb_o, pll_pdb_o, ldo_pdb_o, core_rdy_o;
  logic pwr_on_o, pwr_ok_o, pll_rstb_o, phy_rstb_o, done_o, err_o;
  logic [MODE_W-1:0] mode_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  phy_pwr_seq dut (
    .clk_i, .rst_ni, .start_i, .tick_i, .mode_i, .lock_i,
    .iso_o, .iddq_o, .bg_pdb_o, .pll_pdb_o, .ldo_pdb_o, .core_rdy_o,
    .pwr_on_o, .pwr_ok_o, .mode_o, .pll_rstb_o, .phy_rstb_o, .done_o, .err_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // Runs from start to reset-bar release, checking each step boundary.
  task automatic run_seq(input logic [MODE_W-1:0] m);
    mode_i = m;
    pulse_start();
    chk("R2", "iso after start", iso_o, 1);
    chk("R12", "rstb low after start", {pll_rstb_o, phy_rstb_o, pwr_on_o, pwr_ok_o}, 0);
    ticks(9);  chk("R2", "iddq one tick early", iddq_o, 0);
    ticks(1);  chk("R2", "iddq on time", iddq_o, 1);
    ticks(10);
    chk("R3", "pdb/core cleared", {bg_pdb_o, pll_pdb_o, ldo_pdb_o, core_rdy_o}, 0);
    chk("R3", "mode loaded", mode_o, int'(m));
    ticks(159); chk("R3", "core early", core_rdy_o, 0);
    ticks(1);   chk("R3", "core on time", core_rdy_o, 1);
    ticks(50);  chk("R4", "bg pdb", bg_pdb_o, 1);
    ticks(199); chk("R4", "pwr_on early", pwr_on_o, 0);
    ticks(1);   chk("R5", "pwr_on+ldo", {pwr_on_o, ldo_pdb_o, pwr_ok_o}, 3'b110);
    ticks(10);  chk("R5", "pwr_ok", pwr_ok_o, 1);
    ticks(10);  chk("R6", "pll pdb", pll_pdb_o, 1);
    ticks(10);  chk("R6", "iso released", iso_o, 0);
    ticks(10);  chk("R6", "iddq released, rstb low", {iddq_o, pll_rstb_o, phy_rstb_o}, 0);
    ticks(1);   chk("R6", "both rstb high", {pll_rstb_o, phy_rstb_o}, 2'b11);
  endtask

  task automatic t_reset();
    chk("R1", "outputs in reset", {iso_o, iddq_o, bg_pdb_o, pll_pdb_o, ldo_pdb_o, core_rdy_o,
        pwr_on_o, pwr_ok_o, pll_rstb_o, phy_rstb_o, done_o, err_o, mode_o}, 0);
  endtask

  task automatic t_lock_first();
    lock_i = 1'b1;
    run_seq(3'd6);
    ticks(1);
    chk("R7", "done on first lock", {done_o, err_o}, 2'b10);
    chk("R9", "mode parked pass", mode_o, PARK);
    @(negedge clk_i);
    chk("R11", "done one cycle", done_o, 0);
  endtask

  task automatic t_lock_fail();
    lock_i = 1'b0;
    run_seq(3'd3);
    ticks(7);  chk("R7", "no done while polling", {done_o, pll_rstb_o}, 2'b01);
    ticks(1);  chk("R8", "pll rstb pulsed low", pll_rstb_o, 0);
    @(negedge clk_i);
    chk("R8", "pll rstb back high", pll_rstb_o, 1);
    ticks(7);  chk("R8", "second poll running", {done_o, err_o}, 0);
    ticks(1);  chk("R8", "error with done", {done_o, err_o}, 2'b11);
    chk("R9", "mode parked fail", mode_o, PARK);
    repeat (5) @(negedge clk_i);
    chk("R11", "err sticky", err_o, 1);
  endtask

  task automatic t_busy_start();
    lock_i = 1'b1;
    pulse_start();
    chk("R11", "err cleared by start", err_o, 0);
    ticks(5);
    pulse_start();
    ticks(4);  chk("R10", "busy start ignored, iddq not yet", iddq_o, 0);
    ticks(1);  chk("R10", "iddq on original schedule", iddq_o, 1);
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "reset mid-sequence", {iso_o, iddq_o, err_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_lock_retry();
    lock_i = 1'b0;
    run_seq(3'd5);
    ticks(8);  chk("R8", "pll rstb pulsed low", pll_rstb_o, 0);
    @(negedge clk_i);
    lock_i = 1'b1;
    ticks(1);
    chk("R8", "lock after retry", {done_o, err_o}, 2'b10);
    chk("R9", "mode parked retry", mode_o, PARK);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lock_first();
    t_lock_fail();
    t_busy_start();
    t_lock_retry();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule